// File: doc/BRIEF.md
# Phase-Frequency Detector with Anti-Backlash Overlap

This block compares two one-cycle pulse trains, a divided reference pulse and a divided oscillator pulse. It turns the comparison into a pair of charge-pump enables: an up (source) enable and a down (sink) enable. A rising edge on either input sets a held flag for that side. Once both flags are set, a counter running on the fast system clock keeps both enables on together for a programmable overlap. That overlap is the anti-backlash pulse, and it removes the dead zone for tiny phase errors. When the overlap ends, both flags clear in the same cycle. When the loop is aligned, the only activity is this short overlap.

A swap input exchanges the roles of the two enables, which inverts the sign of the detector gain. A unipolar lock indicator goes low for as many cycles as exactly one flag is held. It stays high while the loop is aligned. Only in the widest overlap setting does the overlap also pull the indicator low. A standby input turns both enables off, holds the indicator high and clears the held state. A three-bit pump current code passes through one register unchanged, for use by analog circuitry outside the block.

Top module: `pfd_antibacklash`

## Requirements
- R1: While reset is asserted and afterwards until a pulse edge arrives, `pumpUp` and `pumpDown` are 0, `lockDet` is 1 and `currentOut` is 0.
- R2: An input edge is a cycle in which the pulse input is 1 after being 0 in the previous cycle. Its flag is set at that clock edge. With `swapPol`=0, when the reference edge comes d cycles before the oscillator edge, `pumpUp` is high for d+W cycles and `pumpDown` for W cycles.
- R3: With `swapPol`=0, when the oscillator edge comes d cycles before the reference edge, `pumpDown` is high for d+W cycles and `pumpUp` for W cycles.
- R4: When both edges arrive in the same cycle, both enables are high together for exactly W cycles, and then both are low.
- R5: The overlap width W is `AB_UNIT` shifted left by `abwCode`. With the default `AB_UNIT`=1, codes 0,1,2,3 give 1,2,4,8 cycles.
- R6: With `swapPol`=1, the reference flag drives `pumpDown` and the oscillator flag drives `pumpUp`.
- R7: `lockDet` is 0 in exactly those cycles in which one flag is held and the other is not. It stays 1 during the overlap when `abwCode` is 0, 1 or 2.
- R8: With `abwCode`=3, `lockDet` is also 0 during the W overlap cycles.
- R9: While `standby` is 1, both enables are 0 and `lockDet` is 1 in the same cycle. Edges seen during standby, and flags held when standby began, produce no enable after release.
- R10: `currentOut` equals the `currentCode` value sampled at the previous clock edge. Codes 0 to 7 stand for increasing current steps.
- R11: Repeated reference edges with no oscillator edge keep `pumpUp` continuously high (with `swapPol`=0) and `lockDet` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that times the overlap |
| rstN | input | 1 | Active-low synchronous reset |
| refPulse | input | 1 | Divided reference pulse |
| vcoPulse | input | 1 | Divided oscillator pulse |
| swapPol | input | 1 | 1 exchanges up and down enables |
| abwCode | input | 2 | Overlap width select, W = AB_UNIT << code |
| standby | input | 1 | Forces enables off and clears state |
| currentCode | input | 3 | Pump current step code |
| pumpUp | output | 1 | Source current enable |
| pumpDown | output | 1 | Sink current enable |
| lockDet | output | 1 | Low while a phase error is held |
| currentOut | output | 3 | Registered copy of currentCode |

## Verification
Suppose a flag is lost or set wrongly. The enable counts for a single reference/oscillator pair then differ from d+W and W within one comparison period, and `lockDet` shows a low window of the wrong length. A stuck or miscounted overlap counter shows up as an overlap that is too long, or one that never ends, by the end of the first pair of edges. Standby state that is cleared incorrectly leaks as a stray enable in the first cycles after release. Each vector therefore counts high cycles per output over a window long enough to hold the whole response.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic setRef;
    logic setVco;
    logic clrBoth;
  } pfdStrobe_t;
endpackage

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
#(
  parameter int AB_UNIT = 1,
  parameter int ABSEL_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refPulse,
  input  logic               vcoPulse,
  input  logic               standby,
  input  logic [ABSEL_W-1:0] abwCode,
  input  logic               refHeld,
  input  logic               vcoHeld,
  output pfdStrobe_t         strobe
);
  localparam int NUM_AB = 1 << ABSEL_W;
  localparam int MAX_W  = AB_UNIT << (NUM_AB - 1);
  localparam int CNT_W  = $clog2(MAX_W + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] widthTab [NUM_AB];
  logic [CNT_W-1:0] abCnt;
  logic refPrev, vcoPrev;
  logic bothHeld, lastCycle;

  // overlap length per code, doubling with each step
  for (genvar i = 0; i < NUM_AB; i++) begin : g_width
    assign widthTab[i] = CNT_W'(AB_UNIT << i);
  end

  assign bothHeld  = refHeld & vcoHeld;
  assign lastCycle = bothHeld && (abCnt == widthTab[abwCode] - ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      vcoPrev <= 1'b0;
      abCnt   <= '0;
    end else begin
      refPrev <= refPulse;
      vcoPrev <= vcoPulse;
      if (standby || !bothHeld || lastCycle) abCnt <= '0;
      else                                   abCnt <= abCnt + ONE;
    end
  end

  always_comb begin
    strobe.setRef  = refPulse & ~refPrev & ~standby;
    strobe.setVco  = vcoPulse & ~vcoPrev & ~standby;
    strobe.clrBoth = lastCycle;
  end
endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int ABSEL_W = 2,
  parameter int CUR_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  pfdStrobe_t         strobe,
  input  logic               standby,
  input  logic               swapPol,
  input  logic [ABSEL_W-1:0] abwCode,
  input  logic [CUR_W-1:0]   currentCode,
  output logic               refHeld,
  output logic               vcoHeld,
  output logic               pumpUp,
  output logic               pumpDown,
  output logic               lockDet,
  output logic [CUR_W-1:0]   currentOut
);
  localparam logic [ABSEL_W-1:0] FULL_CODE = '1;

  logic singleHeld, overlapShown;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refHeld    <= 1'b0;
      vcoHeld    <= 1'b0;
      currentOut <= '0;
    end else begin
      currentOut <= currentCode;
      if (standby) begin
        refHeld <= 1'b0;
        vcoHeld <= 1'b0;
      end else begin
        refHeld <= (refHeld & ~strobe.clrBoth) | strobe.setRef;
        vcoHeld <= (vcoHeld & ~strobe.clrBoth) | strobe.setVco;
      end
    end
  end

  assign singleHeld   = refHeld ^ vcoHeld;
  assign overlapShown = refHeld & vcoHeld & (abwCode == FULL_CODE);

  always_comb begin
    pumpUp   = ~standby & (swapPol ? vcoHeld : refHeld);
    pumpDown = ~standby & (swapPol ? refHeld : vcoHeld);
    lockDet  = standby | ~(singleHeld | overlapShown);
  end
endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash
  import pfd_pkg::*;
#(
  parameter int AB_UNIT = 1,
  parameter int ABSEL_W = 2,
  parameter int CUR_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refPulse,
  input  logic               vcoPulse,
  input  logic               swapPol,
  input  logic [ABSEL_W-1:0] abwCode,
  input  logic               standby,
  input  logic [CUR_W-1:0]   currentCode,
  output logic               pumpUp,
  output logic               pumpDown,
  output logic               lockDet,
  output logic [CUR_W-1:0]   currentOut
);
  pfdStrobe_t strobe;
  logic refHeld, vcoHeld;

  pfd_ctrl #(.AB_UNIT(AB_UNIT), .ABSEL_W(ABSEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .vcoPulse(vcoPulse),
    .standby(standby), .abwCode(abwCode), .refHeld(refHeld),
    .vcoHeld(vcoHeld), .strobe(strobe)
  );

  pfd_datapath #(.ABSEL_W(ABSEL_W), .CUR_W(CUR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .standby(standby),
    .swapPol(swapPol), .abwCode(abwCode), .currentCode(currentCode),
    .refHeld(refHeld), .vcoHeld(vcoHeld), .pumpUp(pumpUp),
    .pumpDown(pumpDown), .lockDet(lockDet), .currentOut(currentOut)
  );
endmodule

// File: rtl/pfd_chk.sv
module pfd_chk #(
  parameter int AB_UNIT = 1,
  parameter int ABSEL_W = 2,
  parameter int CUR_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               standby,
  input logic [ABSEL_W-1:0] abwCode,
  input logic [CUR_W-1:0]   currentCode,
  input logic               pumpUp,
  input logic               pumpDown,
  input logic               lockDet,
  input logic [CUR_W-1:0]   currentOut
);
  localparam int MAX_W = AB_UNIT << ((1 << ABSEL_W) - 1);
  localparam int RUN_W = $clog2(MAX_W + 1) + 1;
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(MAX_W);
  localparam logic [ABSEL_W-1:0] FULL_CODE = '1;

  logic [RUN_W-1:0] overlapRun;

  always_ff @(posedge clk) begin
    if (!rstN) overlapRun <= '0;
    else if (pumpUp && pumpDown) begin
      if (overlapRun != '1) overlapRun <= overlapRun + RUN_W'(1);
    end else overlapRun <= '0;
  end

  // R9
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> (!pumpUp && !pumpDown && lockDet));

  // R5
  overlap_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    overlapRun <= RUN_LIM);

  // R7
  lock_low_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lockDet && abwCode != FULL_CODE) |-> (pumpUp != pumpDown));

  // R7
  idle_lock_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pumpUp && !pumpDown) |-> lockDet);

  // R10
  code_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (currentOut == $past(currentCode)));
endmodule

bind pfd_antibacklash pfd_chk #(.AB_UNIT(AB_UNIT), .ABSEL_W(ABSEL_W), .CUR_W(CUR_W)) u_chk (
  .clk(clk), .rstN(rstN), .standby(standby), .abwCode(abwCode),
  .currentCode(currentCode), .pumpUp(pumpUp), .pumpDown(pumpDown),
  .lockDet(lockDet), .currentOut(currentOut)
);

// File: tb/pfd_antibacklash_tb.sv
`timescale 1ns/1ps
module pfd_antibacklash_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refPulse = 1'b0, vcoPulse = 1'b0, swapPol = 1'b0, standby = 1'b0;
  logic [1:0] abwCode = 2'd0;
  logic [2:0] currentCode = 3'd0;
  logic pumpUp, pumpDown, lockDet;
  logic [2:0] currentOut;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pfd_antibacklash u_dut (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .vcoPulse(vcoPulse),
    .swapPol(swapPol), .abwCode(abwCode), .standby(standby),
    .currentCode(currentCode), .pumpUp(pumpUp), .pumpDown(pumpDown),
    .lockDet(lockDet), .currentOut(currentOut)
  );

  // {swapPol, abwCode, vcoFirst, delay[4:0]}
  localparam logic [8:0] VEC [12] = '{
    {1'b0, 2'd0, 1'b0, 5'd3},  {1'b0, 2'd1, 1'b0, 5'd5},
    {1'b0, 2'd2, 1'b1, 5'd4},  {1'b0, 2'd3, 1'b0, 5'd6},
    {1'b0, 2'd3, 1'b1, 5'd2},  {1'b1, 2'd0, 1'b0, 5'd3},
    {1'b1, 2'd1, 1'b1, 5'd7},  {1'b1, 2'd2, 1'b0, 5'd0},
    {1'b0, 2'd0, 1'b0, 5'd0},  {1'b0, 2'd3, 1'b0, 5'd0},
    {1'b1, 2'd3, 1'b1, 5'd10}, {1'b0, 2'd2, 1'b0, 5'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    chk("R1 pumpUp", pumpUp, 0);
    chk("R1 pumpDown", pumpDown, 0);
    chk("R1 lockDet", lockDet, 1);
    chk("R1 currentOut", currentOut, 0);

    // R10 code pass-through
    currentCode = 3'd5; step();
    chk("R10 code5", currentOut, 5);
    currentCode = 3'd2; step();
    chk("R10 code2", currentOut, 2);
    currentCode = 3'd7; step();
    chk("R10 code7", currentOut, 7);

    // table walk: R2..R8
    for (int v = 0; v < 12; v++) begin
      int d, w, cntUp, cntDn, cntLd, refCnt, vcoCnt, expUp, expDn, expLd;
      bit vf;
      string dirTag;
      swapPol = VEC[v][8];
      abwCode = VEC[v][7:6];
      vf = VEC[v][5];
      d = int'(VEC[v][4:0]);
      repeat (3) step();
      w = 1 << abwCode;                         // R5
      cntUp = 0; cntDn = 0; cntLd = 0;
      for (int s = 0; s < 40; s++) begin
        refPulse = vf ? (s == d) : (s == 0);
        vcoPulse = vf ? (s == 0) : (s == d);
        step();
        cntUp += int'(pumpUp);
        cntDn += int'(pumpDown);
        cntLd += int'(!lockDet);
      end
      refPulse = 0; vcoPulse = 0;
      refCnt = vf ? w : d + w;
      vcoCnt = vf ? d + w : w;
      expUp = swapPol ? vcoCnt : refCnt;        // R6
      expDn = swapPol ? refCnt : vcoCnt;
      expLd = d + ((abwCode == 2'd3) ? w : 0);  // R7 / R8
      dirTag = (d == 0) ? "R4" : (vf ? "R3" : "R2");
      chk($sformatf("%s R5 R6 vec%0d up", dirTag, v), cntUp, expUp);
      chk($sformatf("%s R5 R6 vec%0d down", dirTag, v), cntDn, expDn);
      chk($sformatf("%s vec%0d lockLow", (abwCode == 2'd3) ? "R8" : "R7", v), cntLd, expLd);
    end

    // R11 repeated reference edges, no oscillator edge
    swapPol = 0; abwCode = 2'd0;
    repeat (3) step();
    for (int p = 0; p < 3; p++) begin
      refPulse = 1; step();
      refPulse = 0; repeat (4) step();
    end
    chk("R11 pumpUp held", pumpUp, 1);
    chk("R11 pumpDown", pumpDown, 0);
    chk("R11 lockDet", lockDet, 0);
    vcoPulse = 1; step(); vcoPulse = 0;
    repeat (3) step();
    chk("R11 released up", pumpUp, 0);
    chk("R11 released lock", lockDet, 1);

    // R9 edges during standby are ignored
    standby = 1; refPulse = 1; step(); refPulse = 0;
    chk("R9 up in standby", pumpUp, 0);
    chk("R9 lock in standby", lockDet, 1);
    repeat (2) step();
    vcoPulse = 1; step(); vcoPulse = 0;
    chk("R9 down in standby", pumpDown, 0);
    standby = 0;
    begin
      int leak = 0;
      for (int s = 0; s < 10; s++) begin
        step();
        leak += int'(pumpUp) + int'(pumpDown) + int'(!lockDet);
      end
      chk("R9 no leak after release", leak, 0);
    end

    // R9 standby clears a held flag
    refPulse = 1; step(); refPulse = 0;
    chk("R2 up before standby", pumpUp, 1);
    standby = 1; #1;
    chk("R9 immediate off", pumpUp, 0);
    chk("R9 immediate lock", lockDet, 1);
    step(); standby = 0; step();
    chk("R9 flag cleared", pumpUp, 0);
    chk("R9 lock after clear", lockDet, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule